// File: doc/BRIEF.md
# S/PDIF Input Sample-Rate Mode Detector

This block watches a biphase-mark audio input line that has already been synchronised to a fast reference clock. It estimates the sample rate of the incoming stream and reports it as one of seven rate modes, numbered 0 to 6 from slowest to fastest (32, 44.1, 48, 88.2, 96, 176.4 and 192 kHz), or as code 7 when no usable signal is present. It does this without a PLL and without framing the stream. Over each measurement window it tracks the shortest interval between two consecutive line transitions. At the close of the window it compares twice that interval against a ladder of per-mode thresholds.

Software sets the window length in reference-clock cycles, normally so that one window spans 1 ms. It also loads six 10-bit thresholds, where each threshold is the sum of the half-cell lengths of two neighbouring modes. At every window boundary the block publishes the mode and the measured width. It also updates a sticky, maskable event field that drives one interrupt line. Two hold inputs split the block into a measuring side and a publishing side. Software releases the publishing side first and the measuring side second.

Top module: `spdif_rate_detector`

## Requirements
- R1: After the synchronous reset, `mode` is 7, `width` is 0, `irq_stat` is 0 and `irq` is 0.
- R2: A measurement window lasts `win_len` reference cycles, counted from the first cycle in which measurement runs. At each window end, bit 0 of `irq_stat` (window done) is set.
- R3: An interval is the number of reference cycles between two consecutive changes of `din`. At a window end, `width` takes the smallest interval completed inside that window.
- R4: Threshold i sits in `thr_bus[10*i+9:10*i]`, for i = 0 to 5. At a window end the published mode is the lowest i for which twice the minimum interval is greater than or equal to threshold i. If no threshold is met, the mode is 6.
- R5: If a window completes no interval, the window end publishes mode 7 and width 0, and sets bit 1 of `irq_stat` (no signal).
- R6: The minimum-interval measurement saturates at 1023, so longer intervals report width 1023.
- R7: Bit 2 of `irq_stat` (mode changed) is set at a window end only when the newly published mode differs from the mode published before it.
- R8: `irq_stat` bits are sticky. Writing a one to a bit of `irq_clr` clears that bit, but a set in the same cycle takes precedence. Bits 7:3 always read 0.
- R9: `irq` is a registered output. It is high when some bit of `irq_stat` is set and the matching `irq_mask` bit is 0. A mask bit of 1 hides that bit from `irq`.
- R10: While `en` is 0 or `in_hold` is 1, the window and the interval measurement are stopped and cleared. No window ends, and the published outputs keep their values.
- R11: While `out_hold` is 1, from the next cycle on, `mode` is 7, `width` is 0, `irq_stat` is 0 and `irq` is 0, whatever the input does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Detector enable |
| in_hold | input | 1 | Holds the measuring side in reset |
| out_hold | input | 1 | Holds the published outputs at their idle values |
| din | input | 1 | Synchronised biphase-mark input line |
| win_len | input | 20 | Window length in reference cycles |
| thr_bus | input | 60 | Six 10-bit mode thresholds, threshold i at bits 10*i+9:10*i |
| irq_mask | input | 8 | Per-bit interrupt mask, 1 hides the bit |
| irq_clr | input | 8 | Write-one-to-clear pulses for `irq_stat` |
| mode | output | 3 | Published rate mode, 7 means no signal |
| width | output | 10 | Published minimum interval in reference cycles |
| irq_stat | output | 8 | Sticky event bits: 0 window done, 1 no signal, 2 mode changed |
| irq | output | 1 | Interrupt line |

## Verification
The bench builds the block with its default widths: a 20-bit window, 10-bit widths, seven modes and 8 event bits. It programs a 256-cycle window and thresholds 69, 55, 40, 27, 20 and 13, which keeps half-cells of 3 to 40 cycles inside a window. With these values, every step of the threshold ladder, including the equality cases, can be reached in a few hundred cycles per rate. One run uses a 4000-cycle window with 1100-cycle half-cells, which drives the width counter into saturation.

// File: rtl/srd_pkg.sv
package srd_pkg;
  // Event bit positions inside the interrupt status field
  localparam int unsigned EVT_WIN_DONE  = 0;
  localparam int unsigned EVT_NO_SIGNAL = 1;
  localparam int unsigned EVT_MODE_CHG  = 2;
  localparam int unsigned EVT_USED      = 3;
endpackage

// File: rtl/srd_window_timer.sv
module srd_window_timer #(
  parameter int unsigned WIN_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [WIN_W-1:0] win_len,
  output logic             win_end
);
  logic [WIN_W-1:0] wcnt;
  logic [WIN_W:0]   wcnt_inc;
  logic             at_last;

  assign wcnt_inc = {1'b0, wcnt} + {{WIN_W{1'b0}}, 1'b1};
  assign at_last  = (wcnt_inc >= {1'b0, win_len});
  assign win_end  = run && at_last;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      wcnt <= '0;
    end else if (at_last) begin
      wcnt <= '0;
    end else begin
      wcnt <= wcnt_inc[WIN_W-1:0];
    end
  end
endmodule

// File: rtl/srd_interval_meter.sv
module srd_interval_meter #(
  parameter int unsigned WID_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             din,
  input  logic             win_end,
  output logic             got_nxt,
  output logic [WID_W-1:0] minw_nxt
);
  localparam logic [WID_W-1:0] WMAX = '1;

  logic             din_q;
  logic             tog;
  logic             seen;
  logic             iv_done;
  logic             got;
  logic [WID_W-1:0] gap;
  logic [WID_W-1:0] minw;

  assign tog      = run && (din != din_q);
  assign iv_done  = tog && seen;
  assign minw_nxt = (iv_done && (gap < minw)) ? gap : minw;
  assign got_nxt  = got | iv_done;

  always_ff @(posedge clk) begin
    if (rst) din_q <= 1'b0;
    else     din_q <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      gap  <= '0;
      seen <= 1'b0;
      minw <= WMAX;
      got  <= 1'b0;
    end else begin
      if (tog)              gap <= {{(WID_W-1){1'b0}}, 1'b1};
      else if (gap != WMAX) gap <= gap + 1'b1;
      if (tog) seen <= 1'b1;
      if (win_end) begin
        minw <= WMAX;
        got  <= 1'b0;
      end else begin
        minw <= minw_nxt;
        got  <= got_nxt;
      end
    end
  end
endmodule

// File: rtl/srd_mode_select.sv
module srd_mode_select #(
  parameter int unsigned NUM_MODES = 7,
  parameter int unsigned WID_W     = 10,
  parameter int unsigned MODE_W    = 3
) (
  input  logic                             got,
  input  logic [WID_W-1:0]                 width,
  input  logic [(NUM_MODES-1)*WID_W-1:0]   thr_bus,
  output logic [MODE_W-1:0]                mode
);
  localparam int unsigned NTHR = NUM_MODES - 1;

  logic [NTHR-1:0] meets;

  for (genvar g = 0; g < NTHR; g++) begin : g_cmp
    assign meets[g] = ({width, 1'b0} >= {1'b0, thr_bus[g*WID_W +: WID_W]});
  end

  always_comb begin
    mode = MODE_W'(NUM_MODES - 1);
    for (int i = NTHR - 1; i >= 0; i--) begin
      if (meets[i]) mode = MODE_W'(i);
    end
    if (!got) mode = '1;
  end
endmodule

// File: rtl/srd_publisher.sv
module srd_publisher #(
  parameter int unsigned WID_W  = 10,
  parameter int unsigned MODE_W = 3,
  parameter int unsigned IRQ_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hold,
  input  logic              win_end,
  input  logic              got,
  input  logic [WID_W-1:0]  minw,
  input  logic [MODE_W-1:0] mode_new,
  input  logic [IRQ_W-1:0]  irq_mask,
  input  logic [IRQ_W-1:0]  irq_clr,
  output logic [MODE_W-1:0] mode_q,
  output logic [WID_W-1:0]  width_q,
  output logic [IRQ_W-1:0]  stat_q,
  output logic              irq_q
);
  import srd_pkg::*;

  logic [IRQ_W-1:0] stat_nxt;

  always_comb begin
    stat_nxt = stat_q & ~irq_clr;
    if (win_end) begin
      stat_nxt[EVT_WIN_DONE] = 1'b1;
      if (!got)               stat_nxt[EVT_NO_SIGNAL] = 1'b1;
      if (mode_new != mode_q) stat_nxt[EVT_MODE_CHG]  = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || hold) begin
      mode_q  <= '1;
      width_q <= '0;
      stat_q  <= '0;
      irq_q   <= 1'b0;
    end else begin
      stat_q <= stat_nxt;
      irq_q  <= |(stat_nxt & ~irq_mask);
      if (win_end) begin
        mode_q  <= mode_new;
        width_q <= got ? minw : '0;
      end
    end
  end
endmodule

// File: rtl/spdif_rate_detector.sv
module spdif_rate_detector #(
  parameter int unsigned WIN_W     = 20,
  parameter int unsigned WID_W     = 10,
  parameter int unsigned NUM_MODES = 7,
  parameter int unsigned IRQ_W     = 8
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           en,
  input  logic                           in_hold,
  input  logic                           out_hold,
  input  logic                           din,
  input  logic [WIN_W-1:0]               win_len,
  input  logic [(NUM_MODES-1)*WID_W-1:0] thr_bus,
  input  logic [IRQ_W-1:0]               irq_mask,
  input  logic [IRQ_W-1:0]               irq_clr,
  output logic [$clog2(NUM_MODES+1)-1:0] mode,
  output logic [WID_W-1:0]               width,
  output logic [IRQ_W-1:0]               irq_stat,
  output logic                           irq
);
  localparam int unsigned MODE_W = $clog2(NUM_MODES + 1);

  logic              run;
  logic              win_end;
  logic              got_nxt;
  logic [WID_W-1:0]  minw_nxt;
  logic [MODE_W-1:0] mode_new;

  assign run = en && !in_hold;

  srd_window_timer #(.WIN_W(WIN_W)) u_win (
    .clk(clk), .rst(rst), .run(run), .win_len(win_len), .win_end(win_end)
  );

  srd_interval_meter #(.WID_W(WID_W)) u_meter (
    .clk(clk), .rst(rst), .run(run), .din(din), .win_end(win_end),
    .got_nxt(got_nxt), .minw_nxt(minw_nxt)
  );

  srd_mode_select #(.NUM_MODES(NUM_MODES), .WID_W(WID_W), .MODE_W(MODE_W)) u_sel (
    .got(got_nxt), .width(minw_nxt), .thr_bus(thr_bus), .mode(mode_new)
  );

  srd_publisher #(.WID_W(WID_W), .MODE_W(MODE_W), .IRQ_W(IRQ_W)) u_pub (
    .clk(clk), .rst(rst), .hold(out_hold), .win_end(win_end), .got(got_nxt),
    .minw(minw_nxt), .mode_new(mode_new), .irq_mask(irq_mask), .irq_clr(irq_clr),
    .mode_q(mode), .width_q(width), .stat_q(irq_stat), .irq_q(irq)
  );
endmodule

// File: rtl/srd_checker.sv
module srd_checker #(
  parameter int unsigned MODE_W = 3,
  parameter int unsigned WID_W  = 10,
  parameter int unsigned IRQ_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              out_hold,
  input logic [IRQ_W-1:0]  irq_mask,
  input logic [IRQ_W-1:0]  irq_clr,
  input logic [MODE_W-1:0] mode,
  input logic [WID_W-1:0]  width,
  input logic [IRQ_W-1:0]  irq_stat,
  input logic              irq
);
  import srd_pkg::*;

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    out_hold |=> (mode == '1 && width == '0 && irq_stat == '0 && !irq)); // R11

  AST_STICKY_BITS: assert property (@(posedge clk) disable iff (rst)
    !out_hold |=> ((irq_stat & $past(irq_stat & ~irq_clr)) == $past(irq_stat & ~irq_clr))); // R8

  AST_MODE_CHG_FLAG: assert property (@(posedge clk) disable iff (rst)
    (!$past(out_hold) && !out_hold && mode != $past(mode)) |-> irq_stat[EVT_MODE_CHG]); // R7

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
    1'b1 |-> (irq == |(irq_stat & ~$past(irq_mask)))); // R9

  AST_NOSIG_ZERO_WIDTH: assert property (@(posedge clk) disable iff (rst)
    1'b1 |-> ((mode == '1) == (width == '0))); // R5
endmodule

bind spdif_rate_detector srd_checker #(.MODE_W(MODE_W), .WID_W(WID_W), .IRQ_W(IRQ_W)) u_chk (
  .clk(clk), .rst(rst), .out_hold(out_hold), .irq_mask(irq_mask), .irq_clr(irq_clr),
  .mode(mode), .width(width), .irq_stat(irq_stat), .irq(irq)
);

// File: tb/spdif_rate_detector_tb.sv
`timescale 1ns/1ps
module spdif_rate_detector_tb;
  localparam int NV = 13;
  localparam int VEC_HALF [NV] = '{40, 35, 34, 28, 27, 20, 14, 13, 10, 9, 7, 6, 3};
  localparam int VEC_MODE [NV] = '{ 0,  0,  1,  1,  2,  2,  3,  4,  4, 5, 5, 6, 6};

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en = 1'b0;
  logic        in_hold = 1'b1;
  logic        out_hold = 1'b0;
  logic        din = 1'b0;
  logic [19:0] win_len = 20'd256;
  logic [59:0] thr_bus = {10'd13, 10'd20, 10'd27, 10'd40, 10'd55, 10'd69};
  logic [7:0]  irq_mask = 8'h00;
  logic [7:0]  irq_clr = 8'h00;
  logic [2:0]  mode;
  logic [9:0]  width;
  logic [7:0]  irq_stat;
  logic        irq;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  bit gen_on = 0;
  int half = 10;
  int ph = 0;

  always #4 clk = ~clk;

  spdif_rate_detector u_dut (
    .clk(clk), .rst(rst), .en(en), .in_hold(in_hold), .out_hold(out_hold), .din(din),
    .win_len(win_len), .thr_bus(thr_bus), .irq_mask(irq_mask), .irq_clr(irq_clr),
    .mode(mode), .width(width), .irq_stat(irq_stat), .irq(irq)
  );

  always @(negedge clk) begin
    if (gen_on) begin
      if (ph >= half - 1) begin
        din <= ~din;
        ph  <= 0;
      end else begin
        ph <= ph + 1;
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  // Hold the measuring side, clear all events, load a half-cell, release, settle.
  task automatic run_vec(input int h, input int wait_cycles);
    @(negedge clk);
    in_hold = 1'b1;
    irq_clr = 8'hff;
    half = h;
    @(negedge clk);
    irq_clr = 8'h00;
    @(negedge clk);
    in_hold = 1'b0;
    repeat (wait_cycles) @(negedge clk);
  endtask

  initial begin
    #1200000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual 0 expected 1");
      summary();
      $finish;
    end
  end

  initial begin
    int prev;
    repeat (4) @(negedge clk);
    // R1 reset values
    chk("R1 mode", mode, 7);
    chk("R1 width", width, 0);
    chk("R1 irq_stat", irq_stat, 0);
    chk("R1 irq", irq, 0);
    rst = 1'b0;
    en = 1'b1;
    gen_on = 1'b1;

    // R3 R4 R7 R9 table walk
    prev = 7;
    for (int v = 0; v < NV; v++) begin
      run_vec(VEC_HALF[v], 2 * 256 + 20);
      chk("R4 mode", mode, VEC_MODE[v]);
      chk("R3 width", width, VEC_HALF[v]);
      chk("R2 window done", irq_stat[0], 1);
      chk("R5 no-signal bit clear", irq_stat[1], 0);
      chk("R7 mode change flag", irq_stat[2], (VEC_MODE[v] != prev) ? 1 : 0);
      chk("R9 irq unmasked", irq, 1);
      prev = VEC_MODE[v];
    end

    // R2 window length: first window end exactly 256 cycles after release
    @(negedge clk);
    in_hold = 1'b1;
    irq_clr = 8'hff;
    half = 10;
    @(negedge clk);
    irq_clr = 8'h00;
    @(negedge clk);
    in_hold = 1'b0;
    repeat (250) @(negedge clk);
    chk("R2 no window end before win_len", irq_stat[0], 0);
    repeat (10) @(negedge clk);
    chk("R2 window end after win_len", irq_stat[0], 1);
    chk("R4 equality at threshold", mode, 4);

    // R5 no signal
    gen_on = 1'b0;
    run_vec(10, 2 * 256 + 20);
    chk("R5 mode", mode, 7);
    chk("R5 width", width, 0);
    chk("R5 no-signal bit", irq_stat[1], 1);
    chk("R7 change into no signal", irq_stat[2], 1);

    // R8 write-one-to-clear while measurement is frozen
    @(negedge clk);
    in_hold = 1'b1;
    irq_clr = 8'h02;
    @(negedge clk);
    irq_clr = 8'h00;
    @(negedge clk);
    chk("R8 cleared bit", irq_stat[1], 0);
    chk("R8 other bits kept", irq_stat[2:0], 3'b101);
    chk("R8 upper bits zero", irq_stat[7:3], 0);

    // R9 mask
    irq_mask = 8'h07;
    @(negedge clk);
    chk("R9 all masked", irq, 0);
    irq_mask = 8'h03;
    @(negedge clk);
    chk("R9 bit2 unmasked", irq, 1);
    irq_mask = 8'h00;

    // R10 disable stops windows
    irq_clr = 8'hff;
    @(negedge clk);
    irq_clr = 8'h00;
    gen_on = 1'b1;
    en = 1'b0;
    in_hold = 1'b0;
    repeat (600) @(negedge clk);
    chk("R10 no window while disabled", irq_stat, 0);
    chk("R10 mode kept", mode, 7);
    en = 1'b1;

    // R11 output hold
    @(negedge clk);
    out_hold = 1'b1;
    repeat (600) @(negedge clk);
    chk("R11 mode idle", mode, 7);
    chk("R11 width idle", width, 0);
    chk("R11 stat idle", irq_stat, 0);
    chk("R11 irq idle", irq, 0);
    out_hold = 1'b0;
    run_vec(10, 2 * 256 + 20);
    chk("R11 resumes after release", mode, 4);
    chk("R11 width after release", width, 10);

    // R6 saturation
    win_len = 20'd4000;
    run_vec(1100, 2 * 4000 + 20);
    chk("R6 width saturates", width, 1023);
    chk("R6 mode slowest", mode, 0);

    done = 1;
    summary();
    $finish;
  end
endmodule